// File: doc/BRIEF.md
# I2C Transfer Byte Buffer

This block holds the two byte queues that sit between a host and the shift engine of an I2C master. Bytes the host writes to the data register go into a transmit queue, and the shift engine takes them from there. Bytes the shift engine receives go into a receive queue, and the host reads them from the data register. The host programs a request threshold for each direction. Each time a queue changes, the block decides whether to signal the host with an event pulse.

Before each transfer the host loads a byte count. For each direction the block tracks how many bytes the host still has to move. While that remaining count is at least the threshold, the block raises a ready event whenever a full threshold of bytes can be moved. When fewer bytes than the threshold remain, it raises a drain event instead. The host then reads the exact queue levels from the status register to service the last, partial burst. Writing into a full transmit queue, or an engine pop from an empty one, raises a transmit underflow pulse. An engine push into a full receive queue raises a receive overrun pulse. In each of these cases the byte is dropped.

Host registers, selected by `hostAddr`: 0 is the data register, 1 is the configuration register, 2 is the byte count and 3 is the status register. Queue depth is 8 shifted left by `DEPTH_CODE`, where `DEPTH_CODE` is 0, 1 or 2.

Top module: `i2c_xfer_fifo`

## Requirements
- R1: After reset both queue levels are 0, the configuration and count registers read 0, and no event output is high.
- R2: A configuration write (address 1) stores the transmit threshold minus one from bits [5:0] and the receive threshold minus one from bits [13:8]. Both fields read back at the same positions.
- R3: In a configuration write, bit 6 empties the transmit queue and bit 14 empties the receive queue at that clock edge. Both bits always read back as 0.
- R4: The status register (address 3) shows the transmit level in bits [5:0], the receive level in bits [13:8] and `DEPTH_CODE` in bits [15:14].
- R5: A nonzero write to the count register (address 2) sets the remaining count of both directions and reads back. A write of 0 is ignored.
- R6: The engine pops transmit bytes in the order the host wrote them, taken from data bits [7:0]. Host reads of address 0 return received bytes in push order in bits [7:0], with bits [15:8] at 0. Each accepted host data write lowers the transmit remaining count by one. Each host read from a non-empty receive queue lowers the receive remaining count by one.
- R7: If transmit remaining is at least the threshold and free space is at least the threshold, the transmit-ready pulse fires. If 0 < remaining < threshold and free space is at least the remaining count, the transmit-drain pulse fires instead.
- R8: If receive remaining is at least the threshold and the level is at least the threshold, the receive-ready pulse fires. If 0 < remaining < threshold and the level is at least the remaining count, the receive-drain pulse fires instead.
- R9: A ready or drain event is high only in the cycle right after a clock edge that pushed to, popped from or flushed that queue, or wrote a nonzero count. Ready and drain are never high together.
- R10: A host data write to a full transmit queue, or an engine pop from an empty one, gives a one-cycle underflow pulse in the next cycle and changes no level.
- R11: An engine push into a full receive queue gives a one-cycle overrun pulse in the next cycle, and the byte is dropped.
- R12: A host data read of an empty receive queue returns 0 and leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWrEn | input | 1 | Host register write strobe |
| hostRdEn | input | 1 | Host register read strobe (pops on address 0) |
| hostAddr | input | 2 | Register select |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Host read data for the selected register |
| engTxPop | input | 1 | Engine takes the head transmit byte |
| engTxData | output | 8 | Head transmit byte, 0 when empty |
| engRxPush | input | 1 | Engine delivers a received byte |
| engRxData | input | 8 | Received byte |
| evTxReady | output | 1 | Transmit-ready pulse |
| evTxDrain | output | 1 | Transmit-drain pulse |
| evRxReady | output | 1 | Receive-ready pulse |
| evRxDrain | output | 1 | Receive-drain pulse |
| evTxUnderflow | output | 1 | Transmit underflow pulse |
| evRxOverrun | output | 1 | Receive overrun pulse |

## Verification
The bench sweeps every threshold from 1 to 8 against byte counts from 1 to 12. Transmit writes and engine pops are interleaved, and so are receive pushes and host reads, so the switch from ready to drain is hit at every distance from the end of a transfer. A design that compared against the threshold minus one, or went on raising ready once the remainder fell short, would show the wrong pulse near the last burst. The bench also targets writes into a full queue and pops from an empty one, reads of an empty receive queue, flushes during a transfer and a count write of zero. A design that changed a level on a rejected access or kept a stale byte after a flush would show a wrong status level or data byte.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
  localparam int REG_W = 16;
  localparam int THR_W = 6;
  localparam logic [1:0] ADDR_DATA   = 2'd0;
  localparam logic [1:0] ADDR_CFG    = 2'd1;
  localparam logic [1:0] ADDR_COUNT  = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;
  localparam int TX_FLUSH_BIT = 6;
  localparam int RX_FLUSH_BIT = 14;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobe_t;
endpackage

// File: rtl/i2c_fifo_ring.sv
module i2c_fifo_ring #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [7:0]       pushData,
  output logic [7:0]       headData,
  output logic [LVL_W-1:0] level
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      level <= level + LVL_W'(push) - LVL_W'(pop);
    end
  end
endmodule

// File: rtl/i2c_fifo_datapath.sv
module i2c_fifo_datapath
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobe_t      strobe,
  input  logic [7:0]       txInData,
  input  logic [7:0]       rxInData,
  output logic [7:0]       txHead,
  output logic [7:0]       rxHead,
  output logic [LVL_W-1:0] txLevel,
  output logic [LVL_W-1:0] rxLevel
);
  i2c_fifo_ring #(.DEPTH(DEPTH), .LVL_W(LVL_W)) txRing (
    .clk(clk), .rstN(rstN), .flush(strobe.txFlush), .push(strobe.txPush),
    .pop(strobe.txPop), .pushData(txInData), .headData(txHead), .level(txLevel)
  );

  i2c_fifo_ring #(.DEPTH(DEPTH), .LVL_W(LVL_W)) rxRing (
    .clk(clk), .rstN(rstN), .flush(strobe.rxFlush), .push(strobe.rxPush),
    .pop(strobe.rxPop), .pushData(rxInData), .headData(rxHead), .level(rxLevel)
  );
endmodule

// File: rtl/i2c_fifo_control.sv
module i2c_fifo_control
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH_CODE = 0,
  parameter int DEPTH      = 8,
  parameter int LVL_W      = 4,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  input  logic [1:0]       hostAddr,
  input  logic [REG_W-1:0] hostWrData,
  output logic [REG_W-1:0] hostRdData,
  input  logic             engTxPop,
  input  logic             engRxPush,
  output logic [7:0]       engTxData,
  input  logic [7:0]       txHead,
  input  logic [7:0]       rxHead,
  input  logic [LVL_W-1:0] txLevel,
  input  logic [LVL_W-1:0] rxLevel,
  output fifoStrobe_t      strobe,
  output logic             evTxReady,
  output logic             evTxDrain,
  output logic             evRxReady,
  output logic             evRxDrain,
  output logic             evTxUnderflow,
  output logic             evRxOverrun
);
  logic [THR_W-1:0] txThrM1, rxThrM1;
  logic [CNT_W-1:0] countReg, txRemain, rxRemain;
  logic             txEval, rxEval;

  logic txFull, txEmpty, rxFull, rxEmpty;
  logic dataWr, cfgWr, cntWr, dataRd;
  logic [CNT_W-1:0] txThr, rxThr, txFree, rxLvlExt;
  logic txShort, rxShort;

  assign txFull  = txLevel == LVL_W'(DEPTH);
  assign rxFull  = rxLevel == LVL_W'(DEPTH);
  assign txEmpty = txLevel == '0;
  assign rxEmpty = rxLevel == '0;

  assign dataWr = hostWrEn && hostAddr == ADDR_DATA;
  assign cfgWr  = hostWrEn && hostAddr == ADDR_CFG;
  assign cntWr  = hostWrEn && hostAddr == ADDR_COUNT && hostWrData[CNT_W-1:0] != '0;
  assign dataRd = hostRdEn && hostAddr == ADDR_DATA;

  always_comb begin
    strobe.txFlush = cfgWr && hostWrData[TX_FLUSH_BIT];
    strobe.rxFlush = cfgWr && hostWrData[RX_FLUSH_BIT];
    strobe.txPush  = dataWr && !txFull;
    strobe.txPop   = engTxPop && !txEmpty && !strobe.txFlush;
    strobe.rxPush  = engRxPush && !rxFull && !strobe.rxFlush;
    strobe.rxPop   = dataRd && !rxEmpty;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThrM1       <= '0;
      rxThrM1       <= '0;
      countReg      <= '0;
      txRemain      <= '0;
      rxRemain      <= '0;
      txEval        <= 1'b0;
      rxEval        <= 1'b0;
      evTxUnderflow <= 1'b0;
      evRxOverrun   <= 1'b0;
    end else begin
      if (cfgWr) begin
        txThrM1 <= hostWrData[0 +: THR_W];
        rxThrM1 <= hostWrData[8 +: THR_W];
      end
      if (cntWr) begin
        countReg <= hostWrData[CNT_W-1:0];
        txRemain <= hostWrData[CNT_W-1:0];
        rxRemain <= hostWrData[CNT_W-1:0];
      end else begin
        if (strobe.txPush && txRemain != '0) txRemain <= txRemain - 1'b1;
        if (strobe.rxPop && rxRemain != '0)  rxRemain <= rxRemain - 1'b1;
      end
      txEval <= strobe.txPush || strobe.txPop || strobe.txFlush || cntWr;
      rxEval <= strobe.rxPush || strobe.rxPop || strobe.rxFlush || cntWr;
      evTxUnderflow <= (dataWr && txFull) || (engTxPop && txEmpty);
      evRxOverrun   <= engRxPush && rxFull;
    end
  end

  assign txThr    = CNT_W'(txThrM1) + 1'b1;
  assign rxThr    = CNT_W'(rxThrM1) + 1'b1;
  assign txFree   = CNT_W'(DEPTH) - CNT_W'(txLevel);
  assign rxLvlExt = CNT_W'(rxLevel);
  assign txShort  = txRemain != '0 && txRemain < txThr;
  assign rxShort  = rxRemain != '0 && rxRemain < rxThr;

  assign evTxDrain = txEval && txShort && txFree >= txRemain;
  assign evTxReady = txEval && !txShort && txRemain != '0 && txFree >= txThr;
  assign evRxDrain = rxEval && rxShort && rxLvlExt >= rxRemain;
  assign evRxReady = rxEval && !rxShort && rxRemain != '0 && rxLvlExt >= rxThr;

  assign engTxData = txEmpty ? 8'h00 : txHead;

  always_comb begin
    unique case (hostAddr)
      ADDR_DATA:   hostRdData = rxEmpty ? '0 : {8'h00, rxHead};
      ADDR_CFG:    hostRdData = {2'b00, rxThrM1, 2'b00, txThrM1};
      ADDR_COUNT:  hostRdData = REG_W'(countReg);
      default:     hostRdData = {2'(DEPTH_CODE), 6'(rxLevel), 2'b00, 6'(txLevel)};
    endcase
  end
endmodule

// File: rtl/i2c_xfer_fifo.sv
module i2c_xfer_fifo
  import i2c_fifo_pkg::*;
#(
  parameter int DEPTH_CODE = 0,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [1:0]  hostAddr,
  input  logic [15:0] hostWrData,
  output logic [15:0] hostRdData,
  input  logic        engTxPop,
  output logic [7:0]  engTxData,
  input  logic        engRxPush,
  input  logic [7:0]  engRxData,
  output logic        evTxReady,
  output logic        evTxDrain,
  output logic        evRxReady,
  output logic        evRxDrain,
  output logic        evTxUnderflow,
  output logic        evRxOverrun
);
  localparam int DEPTH = 8 << DEPTH_CODE;
  localparam int LVL_W = $clog2(DEPTH) + 1;

  fifoStrobe_t      strobe;
  logic [7:0]       txHead, rxHead;
  logic [LVL_W-1:0] txLevel, rxLevel;

  i2c_fifo_control #(
    .DEPTH_CODE(DEPTH_CODE), .DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .engTxData(engTxData),
    .txHead(txHead), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .strobe(strobe), .evTxReady(evTxReady), .evTxDrain(evTxDrain),
    .evRxReady(evRxReady), .evRxDrain(evRxDrain),
    .evTxUnderflow(evTxUnderflow), .evRxOverrun(evRxOverrun)
  );

  i2c_fifo_datapath #(.DEPTH(DEPTH), .LVL_W(LVL_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txInData(hostWrData[7:0]),
    .rxInData(engRxData), .txHead(txHead), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel)
  );
endmodule

// File: rtl/i2c_xfer_fifo_check.sv
module i2c_xfer_fifo_check #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWrEn,
  input logic             hostRdEn,
  input logic [1:0]       hostAddr,
  input logic [15:0]      hostWrData,
  input logic [15:0]      hostRdData,
  input logic             engTxPop,
  input logic             engRxPush,
  input logic [LVL_W-1:0] txLevel,
  input logic [LVL_W-1:0] rxLevel,
  input logic             evTxReady,
  input logic             evTxDrain,
  input logic             evRxReady,
  input logic             evRxDrain,
  input logic             evTxUnderflow,
  input logic             evRxOverrun
);
  a_r9_tx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(evTxReady && evTxDrain));

  a_r9_rx_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(evRxReady && evRxDrain));

  a_r9_tx_cause: assert property (@(posedge clk) disable iff (!rstN)
    (evTxReady || evTxDrain) |->
      $past(engTxPop || (hostWrEn && (hostAddr == 2'd0 || hostAddr == 2'd2 ||
                                      (hostAddr == 2'd1 && hostWrData[6])))));

  a_r4_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    txLevel <= LVL_W'(DEPTH) && rxLevel <= LVL_W'(DEPTH));

  a_r10_full_write_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0 && txLevel == LVL_W'(DEPTH)) |=> evTxUnderflow);

  a_r10_empty_pop_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && txLevel == '0) |=> evTxUnderflow);

  a_r11_full_push_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxLevel == LVL_W'(DEPTH)) |=> evRxOverrun);

  a_r11_level_hold: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxLevel == LVL_W'(DEPTH) && !(hostRdEn && hostAddr == 2'd0) &&
     !(hostWrEn && hostAddr == 2'd1 && hostWrData[14])) |=> rxLevel == LVL_W'(DEPTH));

  a_r12_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr == 2'd0 && rxLevel == '0) |-> hostRdData == 16'h0000);

  a_r3_tx_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd1 && hostWrData[6]) |=> txLevel == '0);
endmodule

bind i2c_xfer_fifo i2c_xfer_fifo_check #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk (
  .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
  .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
  .engTxPop(engTxPop), .engRxPush(engRxPush), .txLevel(txLevel),
  .rxLevel(rxLevel), .evTxReady(evTxReady), .evTxDrain(evTxDrain),
  .evRxReady(evRxReady), .evRxDrain(evRxDrain),
  .evTxUnderflow(evTxUnderflow), .evRxOverrun(evRxOverrun)
);

// File: tb/i2c_xfer_fifo_test.sv
module i2c_xfer_fifo_test;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [1:0]  hostAddr = 2'd0;
  logic [15:0] hostWrData = 16'h0;
  logic [15:0] hostRdData;
  logic        engTxPop = 1'b0, engRxPush = 1'b0;
  logic [7:0]  engTxData, engRxData = 8'h0;
  logic        evTxReady, evTxDrain, evRxReady, evRxDrain, evTxUnderflow, evRxOverrun;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int mTxLvl = 0, mRxLvl = 0, mTxRem = 0, mRxRem = 0, mCount = 0;
  int mTxThr = 1, mRxThr = 1;
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  logic [7:0] nextByte = 8'h11;

  always #4 clk = ~clk;

  i2c_xfer_fifo uut (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .engTxPop(engTxPop), .engTxData(engTxData), .engRxPush(engRxPush),
    .engRxData(engRxData), .evTxReady(evTxReady), .evTxDrain(evTxDrain),
    .evRxReady(evRxReady), .evRxDrain(evRxDrain),
    .evTxUnderflow(evTxUnderflow), .evRxOverrun(evRxOverrun)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock cycle of stimulus with model-based checking.
  task automatic cyc(input bit wr, input logic [1:0] a, input logic [15:0] wd,
                     input bit rd, input bit pop, input bit push,
                     input logic [7:0] pb, input string tag);
    bit dataWr, cfgWr, cntWr, txFl, rxFl, txPushOk, txPopOk, rxPushOk, rxPopOk;
    bit expUnder, expOver, txEv, rxEv, txShort, rxShort;
    logic [5:0] expEv, actEv;
    logic [15:0] expRd;
    hostWrEn = wr; hostAddr = a; hostWrData = wd; hostRdEn = rd;
    engTxPop = pop; engRxPush = push; engRxData = pb;
    #1;
    dataWr = wr && a == 2'd0;
    cfgWr  = wr && a == 2'd1;
    cntWr  = wr && a == 2'd2 && wd != 16'h0;
    txFl   = cfgWr && wd[6];
    rxFl   = cfgWr && wd[14];
    expUnder = (dataWr && mTxLvl == DEPTH) || (pop && mTxLvl == 0);
    expOver  = push && mRxLvl == DEPTH;
    txPushOk = dataWr && mTxLvl < DEPTH;
    txPopOk  = pop && mTxLvl > 0 && !txFl;
    rxPushOk = push && mRxLvl < DEPTH && !rxFl;
    rxPopOk  = rd && a == 2'd0 && mRxLvl > 0;
    if (rd) begin
      case (a)
        2'd0: expRd = (mRxLvl > 0) ? {8'h00, rxQ[0]} : 16'h0;
        2'd1: expRd = {2'b00, 6'(mRxThr - 1), 2'b00, 6'(mTxThr - 1)};
        2'd2: expRd = 16'(mCount);
        default: expRd = {2'b00, 6'(mRxLvl), 2'b00, 6'(mTxLvl)};
      endcase
      check(hostRdData == expRd, {tag, " read"}, hostRdData, expRd);
    end
    if (txPopOk) check(engTxData == txQ[0], "R6 engine byte", engTxData, txQ[0]);
    if (txFl) txQ.delete();
    else begin
      if (txPopOk) void'(txQ.pop_front());
      if (txPushOk) txQ.push_back(wd[7:0]);
    end
    if (rxFl) rxQ.delete();
    else begin
      if (rxPopOk) void'(rxQ.pop_front());
      if (rxPushOk) rxQ.push_back(pb);
    end
    mTxLvl = txQ.size();
    mRxLvl = rxQ.size();
    if (cfgWr) begin
      mTxThr = int'(wd[5:0]) + 1;
      mRxThr = int'(wd[13:8]) + 1;
    end
    if (cntWr) begin
      mCount = wd; mTxRem = wd; mRxRem = wd;
    end else begin
      if (txPushOk && mTxRem > 0) mTxRem--;
      if (rxPopOk && mRxRem > 0) mRxRem--;
    end
    txEv = txPushOk || txPopOk || txFl || cntWr;
    rxEv = rxPushOk || rxPopOk || rxFl || cntWr;
    txShort = mTxRem != 0 && mTxRem < mTxThr;
    rxShort = mRxRem != 0 && mRxRem < mRxThr;
    expEv[5] = txEv && !txShort && mTxRem != 0 && (DEPTH - mTxLvl) >= mTxThr;  // R7 ready
    expEv[4] = txEv && txShort && (DEPTH - mTxLvl) >= mTxRem;                  // R7 drain
    expEv[3] = rxEv && !rxShort && mRxRem != 0 && mRxLvl >= mRxThr;            // R8 ready
    expEv[2] = rxEv && rxShort && mRxLvl >= mRxRem;                            // R8 drain
    expEv[1] = expUnder;                                                       // R10
    expEv[0] = expOver;                                                        // R11
    @(posedge clk);
    #1;
    actEv = {evTxReady, evTxDrain, evRxReady, evRxDrain, evTxUnderflow, evRxOverrun};
    check(actEv == expEv, {tag, " events R7/R8/R9/R10/R11"}, actEv, expEv);
    hostWrEn = 1'b0; hostRdEn = 1'b0; engTxPop = 1'b0; engRxPush = 1'b0;
  endtask

  task automatic idleRead(input logic [1:0] a, input string tag);
    cyc(1'b0, a, 16'h0, 1'b1, 1'b0, 1'b0, 8'h0, tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1: reset state
    check({evTxReady, evTxDrain, evRxReady, evRxDrain, evTxUnderflow, evRxOverrun} == 6'b0,
          "R1 events after reset", 0, 0);
    idleRead(2'd1, "R1 config");
    idleRead(2'd2, "R1 count");
    idleRead(2'd3, "R1 R4 status");
    // R2: thresholds
    cyc(1'b1, 2'd1, 16'h0503, 1'b0, 1'b0, 1'b0, 8'h0, "R2 cfg write");
    idleRead(2'd1, "R2 cfg readback");
    // R5: zero count ignored, nonzero count stored
    cyc(1'b1, 2'd2, 16'h0000, 1'b0, 1'b0, 1'b0, 8'h0, "R5 zero count");
    idleRead(2'd2, "R5 zero ignored");
    cyc(1'b1, 2'd2, 16'd10, 1'b0, 1'b0, 1'b0, 8'h0, "R5 count write");
    idleRead(2'd2, "R5 count readback");

    // Sweep thresholds and transfer lengths
    for (int thr = 1; thr <= DEPTH; thr++) begin
      for (int cnt = 1; cnt <= 12; cnt++) begin
        int rth;
        int pushed;
        int i;
        rth = ((thr + 2) % DEPTH) + 1;
        cyc(1'b1, 2'd1, {1'b0, 1'b1, 6'(rth - 1), 1'b0, 1'b1, 6'(thr - 1)},
            1'b0, 1'b0, 1'b0, 8'h0, "R3 flush both");
        idleRead(2'd1, "R3 flush bits read 0");
        idleRead(2'd3, "R3 R4 status after flush");
        cyc(1'b1, 2'd2, 16'(cnt), 1'b0, 1'b0, 1'b0, 8'h0, "R5 count");
        i = 0;
        while (mTxRem > 0 || mTxLvl > 0) begin
          if ((i % 3) != 2 && mTxRem > 0 && mTxLvl < DEPTH) begin
            cyc(1'b1, 2'd0, {8'h00, nextByte}, 1'b0, 1'b0, 1'b0, 8'h0, "R6 R7 tx write");
            nextByte = nextByte + 8'd7;
          end else if (mTxLvl > 0)
            cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0, 8'h0, "R6 R7 engine pop");
          idleRead(2'd3, "R4 R9 tx status");
          i++;
        end
        pushed = 0;
        i = 0;
        while (mRxRem > 0) begin
          if (((i % 3) != 2 || mRxLvl == 0) && pushed < cnt && mRxLvl < DEPTH) begin
            cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b1, nextByte, "R6 R8 engine push");
            nextByte = nextByte + 8'd5;
            pushed++;
          end else
            cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 1'b0, 8'h0, "R6 R8 host read");
          idleRead(2'd3, "R4 R9 rx status");
          i++;
        end
      end
    end

    // R10: write into a full transmit queue
    cyc(1'b1, 2'd2, 16'd20, 1'b0, 1'b0, 1'b0, 8'h0, "R5 count");
    for (int k = 0; k < DEPTH; k++)
      cyc(1'b1, 2'd0, 16'(k + 8'h40), 1'b0, 1'b0, 1'b0, 8'h0, "R10 fill tx");
    cyc(1'b1, 2'd0, 16'h00EE, 1'b0, 1'b0, 1'b0, 8'h0, "R10 write when full");
    idleRead(2'd3, "R10 level unchanged");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0, 8'h0, "R6 head after reject");
    // R3: tx flush mid-transfer then R10 pop from empty
    cyc(1'b1, 2'd1, 16'h0043, 1'b0, 1'b0, 1'b0, 8'h0, "R3 tx flush");
    idleRead(2'd3, "R3 tx level zero");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b1, 1'b0, 8'h0, "R10 pop when empty");
    idleRead(2'd3, "R10 level stays zero");
    // R11: overrun
    for (int k = 0; k < DEPTH; k++)
      cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b1, 8'(k + 8'h80), "R11 fill rx");
    cyc(1'b0, 2'd0, 16'h0, 1'b0, 1'b0, 1'b1, 8'hDD, "R11 push when full");
    idleRead(2'd3, "R11 level held");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 1'b0, 8'h0, "R11 first byte kept");
    // R3 rx flush, then R12 empty read
    cyc(1'b1, 2'd1, 16'h4303, 1'b0, 1'b0, 1'b0, 8'h0, "R3 rx flush");
    idleRead(2'd3, "R3 rx level zero");
    cyc(1'b0, 2'd0, 16'h0, 1'b1, 1'b0, 1'b0, 8'h0, "R12 empty read");
    idleRead(2'd3, "R12 level unchanged");
    idleRead(2'd2, "R12 count unchanged");

    finishRun();
  end
endmodule